// File: doc/BRIEF.md
# MSI vector capture interrupt controller

This block sits beside the root-complex inbound write path. It watches for message-signalled interrupt writes aimed at one 4-byte window. The 32-bit data word of such a write is a vector number from 0 to 63. The block records each vector as a pending bit in one of two 32-bit status words and raises a single level interrupt toward the host.

Host software services the interrupt through a small register port. The port holds two enable words, which are plain storage, and two status words. Writing a 1 to a status bit clears that bit. Clear writes follow special rules that decide whether the interrupt line drops:

- A write of zero does nothing.
- A write of all ones wipes the word and leaves the line as it was. This is initialisation, not servicing a source.
- Any other clear drops the line once both status words are empty.

Registers update on the rising clock edge. Register reads are combinational from the current state.

Top module: `msi_capture_irq`

## Requirements
- R1: An accepted MSI write with vector v < 32 sets bit v of the status word at offset 0xE8, visible from the next cycle.
- R2: An accepted MSI write with vector v in 32..63 sets bit v-32 of the status word at offset 0xEC, visible from the next cycle.
- R3: A write is accepted when `msi_valid_i` is high, `msi_addr_i` equals the window base (default 0x1E77005C) and `msi_be_i` is 4'hF. An accepted write drives `irq_o` high from the next cycle.
- R4: MSI writes to any other address, or with any byte enable other than 4'hF, change no status bit and leave `irq_o` unchanged.
- R5: MSI writes whose vector is 64 or more are dropped. They change no status bit and leave `irq_o` unchanged.
- R6: A register write of zero to either status word changes nothing.
- R7: A nonzero register write to a status word clears exactly the bits that are 1 in the written data.
- R8: A status write of 0xFFFFFFFF clears that word and leaves `irq_o` unchanged.
- R9: After any other nonzero status write, `irq_o` goes low when both status words are then zero. Otherwise it stays high.
- R10: If an MSI capture and a status clear hit the same word in one cycle, the captured bit ends up set and `irq_o` is high.
- R11: The enable words at offsets 0xE0 and 0xE4 read back what was written. They do not gate capture.
- R12: After reset, all four registers read zero and `irq_o` is low. Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| msi_valid_i | input | 1 | Inbound write strobe |
| msi_addr_i | input | 32 | Inbound write address |
| msi_data_i | input | 32 | Inbound write data (vector number) |
| msi_be_i | input | 4 | Inbound write byte enables |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt to host |

## Verification
The bench hits both ends of each status word (vectors 0, 31, 32 and 63) and the first dropped vector, 64. A wrong split would put a bit in the wrong word, and a missing range check would alias vector 64 onto bit 0.

It runs three kinds of clear on a pending interrupt: a zero write, an all-ones write and a partial clear that leaves the other word nonzero. A design that treats all-ones as ordinary servicing would drop the line early. One that does not check both words would drop it while vectors are still pending.

A same-cycle capture and clear on one word exposes a design that lets the clear win. Near-miss addresses and partial byte enables catch a window decode that is too loose.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned NUM_VEC     = 64;
  localparam int unsigned REG_AW      = 8;
  localparam logic [31:0] WIN_BASE    = 32'h1E77_005C;
  localparam logic [7:0]  EN_OFF      = 8'hE0;
  localparam logic [7:0]  STS_OFF     = 8'hE8;
endpackage

// File: rtl/msi_window_decode.sv
module msi_window_decode #(
  parameter int unsigned      DATA_W    = 32,
  parameter int unsigned      NUM_VEC   = 64,
  parameter logic [31:0]      WIN_BASE  = 32'h1E77_005C,
  localparam int unsigned     NUM_WORDS = NUM_VEC / DATA_W,
  localparam int unsigned     BIT_W     = $clog2(DATA_W)
) (
  input  logic                                 msi_valid_i,
  input  logic [31:0]                          msi_addr_i,
  input  logic [DATA_W-1:0]                    msi_data_i,
  input  logic [DATA_W/8-1:0]                  msi_be_i,
  output logic                                 cap_o,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]     set_mask_o
);
  logic hit, vec_ok;
  logic [BIT_W-1:0] bit_idx;

  assign hit     = msi_valid_i && (msi_addr_i == WIN_BASE) && (&msi_be_i);
  assign vec_ok  = msi_data_i < DATA_W'(NUM_VEC);
  assign cap_o   = hit && vec_ok;
  assign bit_idx = msi_data_i[BIT_W-1:0];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic sel;
    assign sel = cap_o && ((msi_data_i >> BIT_W) == DATA_W'(w));
    assign set_mask_o[w] = sel ? (DATA_W'(1) << bit_idx) : '0;
  end
endmodule

// File: rtl/msi_status_word.sv
module msi_status_word #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] sts_d_o,
  output logic [DATA_W-1:0] sts_q_o
);
  // capture wins over a same-cycle clear
  assign sts_d_o = (sts_q_o & ~clr_i) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q_o <= '0;
    else         sts_q_o <= sts_d_o;
  end
endmodule

// File: rtl/msi_irq_level.sv
module msi_irq_level (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic svc_clr_i,
  input  logic all_clear_i,
  output logic irq_o
);
  logic irq_d;

  always_comb begin
    irq_d = irq_o;
    if (cap_i)                          irq_d = 1'b1;
    else if (svc_clr_i && all_clear_i)  irq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_d;
  end
endmodule

// File: rtl/msi_capture_irq.sv
module msi_capture_irq
  import msi_cap_pkg::*;
#(
  parameter int unsigned     P_DATA_W  = DATA_W,
  parameter int unsigned     P_NUM_VEC = NUM_VEC,
  parameter int unsigned     P_REG_AW  = REG_AW,
  parameter logic [31:0]     P_WIN     = WIN_BASE,
  parameter logic [7:0]      P_EN_OFF  = EN_OFF,
  parameter logic [7:0]      P_STS_OFF = STS_OFF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  msi_valid_i,
  input  logic [31:0]           msi_addr_i,
  input  logic [P_DATA_W-1:0]   msi_data_i,
  input  logic [P_DATA_W/8-1:0] msi_be_i,
  input  logic                  reg_we_i,
  input  logic [P_REG_AW-1:0]   reg_addr_i,
  input  logic [P_DATA_W-1:0]   reg_wdata_i,
  output logic [P_DATA_W-1:0]   reg_rdata_o,
  output logic                  irq_o
);
  localparam int unsigned NUM_WORDS = P_NUM_VEC / P_DATA_W;
  localparam int unsigned STRIDE    = P_DATA_W / 8;

  logic                                 cap;
  logic [NUM_WORDS-1:0][P_DATA_W-1:0]   set_mask, clr_mask, sts_d, sts_q, en_q;
  logic [NUM_WORDS-1:0]                 sts_hit, en_hit;
  logic [P_NUM_VEC-1:0]                 sts_all;
  logic                                 wdata_nz, wdata_ones, svc_clr;

  msi_window_decode #(
    .DATA_W(P_DATA_W), .NUM_VEC(P_NUM_VEC), .WIN_BASE(P_WIN)
  ) u_dec (
    .msi_valid_i(msi_valid_i), .msi_addr_i(msi_addr_i),
    .msi_data_i(msi_data_i),   .msi_be_i(msi_be_i),
    .cap_o(cap),               .set_mask_o(set_mask)
  );

  assign wdata_nz   = |reg_wdata_i;
  assign wdata_ones = &reg_wdata_i;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_w
    localparam logic [P_REG_AW-1:0] EN_A  = P_REG_AW'(P_EN_OFF)  + P_REG_AW'(STRIDE * w);
    localparam logic [P_REG_AW-1:0] STS_A = P_REG_AW'(P_STS_OFF) + P_REG_AW'(STRIDE * w);

    assign en_hit[w]   = reg_we_i && (reg_addr_i == EN_A);
    assign sts_hit[w]  = reg_we_i && (reg_addr_i == STS_A);
    assign clr_mask[w] = sts_hit[w] ? reg_wdata_i : '0;

    msi_status_word #(.DATA_W(P_DATA_W)) u_sts (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(set_mask[w]), .clr_i(clr_mask[w]),
      .sts_d_o(sts_d[w]), .sts_q_o(sts_q[w])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       en_q[w] <= '0;
      else if (en_hit[w]) en_q[w] <= reg_wdata_i;
    end

    assign sts_all[w*P_DATA_W +: P_DATA_W] = sts_q[w];
  end

  // all-ones is initialisation, not servicing
  assign svc_clr = (|sts_hit) && wdata_nz && !wdata_ones;

  msi_irq_level u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cap_i(cap), .svc_clr_i(svc_clr), .all_clear_i(~|sts_d),
    .irq_o(irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int w = 0; w < int'(NUM_WORDS); w++) begin
      if (reg_addr_i == P_REG_AW'(P_EN_OFF) + P_REG_AW'(STRIDE * w))  reg_rdata_o = en_q[w];
      if (reg_addr_i == P_REG_AW'(P_STS_OFF) + P_REG_AW'(STRIDE * w)) reg_rdata_o = sts_q[w];
    end
  end
endmodule

// File: rtl/msi_capture_irq_chk.sv
module msi_capture_irq_chk #(
  parameter logic [31:0] WIN   = 32'h1E77_005C,
  parameter logic [7:0]  STS0  = 8'hE8,
  parameter logic [7:0]  STS1  = 8'hEC
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        msi_valid_i,
  input logic [31:0] msi_addr_i,
  input logic [31:0] msi_data_i,
  input logic [3:0]  msi_be_i,
  input logic        reg_we_i,
  input logic [7:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic        irq_o,
  input logic [63:0] sts_i
);
  logic acc, sts_wr;
  logic [63:0] vec_mask;
  assign acc      = msi_valid_i && msi_addr_i == WIN && msi_be_i == 4'hF && msi_data_i < 32'd64;
  assign sts_wr   = reg_we_i && (reg_addr_i == STS0 || reg_addr_i == STS1);
  assign vec_mask = 64'd1 << msi_data_i[5:0];

  // R3
  cap_raises_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> irq_o);

  // R10
  cap_bit_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> ((sts_i & $past(vec_mask)) == $past(vec_mask)));

  // R5
  big_vec_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msi_valid_i && msi_data_i >= 32'd64 && !reg_we_i) |=> ($stable(sts_i) && $stable(irq_o)));

  // R6
  zero_clear_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && reg_wdata_i == 32'd0 && !msi_valid_i) |=> ($stable(sts_i) && $stable(irq_o)));

  // R8
  init_keeps_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && reg_wdata_i == 32'hFFFF_FFFF && !msi_valid_i) |=> (irq_o == $past(irq_o)));

  // R9
  svc_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && reg_wdata_i != 32'd0 && reg_wdata_i != 32'hFFFF_FFFF && !msi_valid_i)
      |=> (sts_i != 64'd0 || !irq_o));
endmodule

bind msi_capture_irq msi_capture_irq_chk #(
  .WIN(P_WIN), .STS0(P_STS_OFF), .STS1(P_STS_OFF + 8'd4)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .msi_valid_i(msi_valid_i), .msi_addr_i(msi_addr_i),
  .msi_data_i(msi_data_i), .msi_be_i(msi_be_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .irq_o(irq_o), .sts_i(sts_all)
);

// File: tb/msi_capture_irq_tb.sv
`timescale 1ns/1ps
module msi_capture_irq_tb;
  localparam logic [31:0] WIN = 32'h1E77_005C;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        msi_valid_i = 1'b0;
  logic [31:0] msi_addr_i = '0, msi_data_i = '0;
  logic [3:0]  msi_be_i = '0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        irq_o;

  int checks = 0, errors = 0;
  logic [31:0] m_sts [2];
  logic [31:0] m_en  [2];
  logic        m_irq;

  always #5 clk_i = ~clk_i;

  msi_capture_irq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .msi_valid_i(msi_valid_i), .msi_addr_i(msi_addr_i),
    .msi_data_i(msi_data_i), .msi_be_i(msi_be_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // Expected next state, taken from the requirements
  function automatic void model(logic mv, logic [31:0] ma, logic [31:0] md, logic [3:0] mb,
                                logic we, logic [7:0] ra, logic [31:0] wd);
    logic cap, svc;
    cap = mv && ma == WIN && mb == 4'hF && md < 64;
    svc = 1'b0;
    for (int k = 0; k < 2; k++) begin
      if (we && ra == 8'hE0 + 8'(4*k)) m_en[k] = wd;
      if (we && ra == 8'hE8 + 8'(4*k) && wd != 0) begin
        m_sts[k] &= ~wd;
        if (wd != 32'hFFFF_FFFF) svc = 1'b1;
      end
    end
    if (cap) m_sts[md[5]][md[4:0]] = 1'b1;
    if (cap) m_irq = 1'b1;
    else if (svc && m_sts[0] == 0 && m_sts[1] == 0) m_irq = 1'b0;
  endfunction

  task automatic op(logic mv, logic [31:0] ma, logic [31:0] md, logic [3:0] mb,
                    logic we, logic [7:0] ra, logic [31:0] wd);
    @(negedge clk_i);
    msi_valid_i = mv; msi_addr_i = ma; msi_data_i = md; msi_be_i = mb;
    reg_we_i = we; reg_addr_i = ra; reg_wdata_i = wd;
    @(posedge clk_i);
    #1;
    msi_valid_i = 1'b0; reg_we_i = 1'b0;
    model(mv, ma, md, mb, we, ra, wd);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #0.5;
    d = reg_rdata_o;
  endtask

  task automatic verify(string req);
    logic [31:0] d;
    rd(8'hE8, d); check({req, " sts0"}, d, m_sts[0]);
    rd(8'hEC, d); check({req, " sts1"}, d, m_sts[1]);
    rd(8'hE0, d); check({req, " en0"}, d, m_en[0]);
    rd(8'hE4, d); check({req, " en1"}, d, m_en[1]);
    check({req, " irq"}, {31'd0, irq_o}, {31'd0, m_irq});
  endtask

  task automatic msi(logic [31:0] v);
    op(1'b1, WIN, v, 4'hF, 1'b0, 8'h00, 32'h0);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    op(1'b0, 32'h0, 32'h0, 4'h0, 1'b1, a, d);
  endtask

  initial begin
    logic [31:0] d;
    int unsigned junk;
    junk = $urandom(32'd20250919);
    m_sts[0] = 0; m_sts[1] = 0; m_en[0] = 0; m_en[1] = 0; m_irq = 0;
    #23 rst_ni = 1'b1;
    #1;
    verify("R12 reset");
    rd(8'h00, d); check("R12 unmapped", d, 32'h0);

    msi(32'd0);  verify("R1 vec0");
    msi(32'd31); verify("R1 vec31");
    msi(32'd32); verify("R2 vec32");
    msi(32'd63); verify("R2 vec63");
    msi(32'd64); verify("R5 vec64");
    msi(32'hFFFF_FFFF); verify("R5 vecmax");
    op(1'b1, WIN + 4, 32'd5, 4'hF, 1'b0, 8'h0, 0); verify("R4 addr");
    op(1'b1, WIN, 32'd5, 4'h3, 1'b0, 8'h0, 0);     verify("R4 be");
    wr(8'hE8, 32'h0);        verify("R6 zero");
    wr(8'hE8, 32'h8000_0001); verify("R7 partial");
    check("R9 irq held", {31'd0, irq_o}, 32'd1);
    wr(8'hEC, 32'hFFFF_FFFF); verify("R8 init");
    check("R8 irq kept", {31'd0, irq_o}, 32'd1);
    msi(32'd40);
    wr(8'hEC, 32'h0000_0100); verify("R9 drop");
    check("R9 irq low", {31'd0, irq_o}, 32'd0);
    op(1'b1, WIN, 32'd3, 4'hF, 1'b1, 8'hE8, 32'h0000_0008); verify("R10 race");
    check("R10 irq", {31'd0, irq_o}, 32'd1);
    wr(8'hE0, 32'hA5A5_0000); wr(8'hE4, 32'h0000_5A5A); verify("R11 en");
    wr(8'hE0, 32'h0); msi(32'd7); verify("R11 nogate");

    for (int i = 0; i < 500; i++) begin
      int unsigned kind = $urandom % 8;
      logic [31:0] v = $urandom % 64;
      logic [7:0]  sa = ($urandom % 2) ? 8'hEC : 8'hE8;
      logic [31:0] mask;
      case ($urandom % 4)
        0: mask = 32'h0;
        1: mask = 32'hFFFF_FFFF;
        default: mask = $urandom;
      endcase
      case (kind)
        0, 1: msi(v);
        2: msi(32'd64 + ($urandom % 1000));
        3: op(1'b1, WIN ^ (32'd1 << ($urandom % 32)), v, 4'hF, 1'b0, 8'h0, 0);
        4: op(1'b1, WIN, v, 4'($urandom % 15), 1'b0, 8'h0, 0);
        5: wr(sa, mask);
        6: wr(($urandom % 2) ? 8'hE0 : 8'hE4, $urandom);
        default: op(1'b1, WIN, v, 4'hF, 1'b1, sa, mask);
      endcase
      verify("R7 R9 R10 rand");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule